// File: doc/BRIEF.md
# Read-to-Clear Interrupt Status Controller

This block gathers interrupt events from seven sources into one 32-bit pending register and drives a single interrupt line to the CPU. The sources are two timer channels, a UART, an external pin, a wakeup request and two peripheral-block requests. Each pending bit is sticky. It is set on a rising edge of its source and cleared when the CPU reads the status register. Only the byte lanes named by the read's byte enables are cleared.

A second 32-bit register enables the five low sources one by one. The two peripheral requests skip that register entirely. Their live request levels also feed the interrupt line directly, so the line stays active after their pending bits are cleared, until the peripheral drops its request. Software reads the status register at byte offset 0 and reads or writes the enable register at byte offset 4. Every access is a single-cycle read or write with byte enables.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status register, the enable register and `irq_o` are all zero.
- R2: A rising edge on a source sets a fixed status bit. Timer channel 0 sets bit 0, timer channel 1 sets bit 1, the UART sets bit 2, the external pin sets bit 3 and wakeup sets bit 4. Peripheral request 0 sets bit 16 and peripheral request 1 sets bit 17. Every other status bit reads as 0.
- R3: A pending bit stays set until a clearing read. An input held high sets its bit once only, so after the clear it does not set the bit again without a new rising edge.
- R4: A status read with byte enable 0 set clears bits 0 to 4. A status read without that enable leaves bits 0 to 4 unchanged.
- R5: A status read with byte enable 2 set clears bits 16 and 17. A status read without that enable leaves bits 16 and 17 unchanged.
- R6: If a source's rising edge arrives in the same cycle as a read that clears its bit, the bit ends up set.
- R7: The enable register can be read and written at offset 4, with a byte enable for each byte. Only bits 0 to 4 can be stored. All other bits read as 0, and a byte lane whose enable is clear is not written.
- R8: `irq_o` is registered. It rises one clock after a status bit in 0 to 4 and its enable bit are both set, and it stays low when the enable bit is clear.
- R9: A pending bit 16 or 17 drives `irq_o` high regardless of the enable register.
- R10: While a peripheral request input is high, `irq_o` stays high even after its pending bit has been cleared. `irq_o` falls one clock after the request drops.
- R11: The UART bit is set by a rising edge of the OR of its four conditions: receive full, transmit empty, line status and modem status.
- R12: Writes to the status register offset have no effect on its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Byte offset: 0 = status, 4 = enable |
| acc_be | input | 4 | Byte enables |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the access cycle |
| tmr0_evt | input | 1 | Timer channel 0 event level |
| tmr1_evt | input | 1 | Timer channel 1 event level |
| uart_rx_full | input | 1 | UART receive buffer full |
| uart_tx_empty | input | 1 | UART transmit buffer empty |
| uart_line_st | input | 1 | UART line status condition |
| uart_modem_st | input | 1 | UART modem status condition |
| ext_evt | input | 1 | External interrupt level |
| wake_evt | input | 1 | Wakeup request level |
| per0_req | input | 1 | Peripheral 0 request level (unmaskable) |
| per1_req | input | 1 | Peripheral 1 request level (unmaskable) |
| irq_o | output | 1 | Interrupt line to the CPU |

## Verification
The hardest case to reach from the ports is a source edge landing in the very cycle that a clearing read retires. The stimulus raises the timer input on the same falling clock edge that starts the status read, so the edge and the clear meet at the same rising edge. The second hard case is a cleared peripheral bit while its request is still high. The bench holds the peripheral request, clears bit 16 through a lane-2 read, and then watches `irq_o` stay high until the request is released.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int DW       = 32;
    localparam int LANES    = DW / 8;
    localparam int NSRC     = 7;
    localparam int B_TM0    = 0;
    localparam int B_TM1    = 1;
    localparam int B_UART   = 2;
    localparam int B_EXT    = 3;
    localparam int B_WAKE   = 4;
    localparam int B_PER0   = 16;
    localparam int B_PER1   = 17;
    localparam int LOW_LANE  = B_TM0 / 8;
    localparam int HIGH_LANE = B_PER0 / 8;
    localparam logic [DW-1:0] LOW_GRP  = 32'h0000_001F;
    localparam logic [DW-1:0] HIGH_GRP = 32'h0003_0000;
    localparam logic [DW-1:0] IMPL     = LOW_GRP | HIGH_GRP;
    localparam logic [DW-1:0] MASKABLE = LOW_GRP;

    typedef struct packed {
        logic [DW-1:0] stat;
        logic [DW-1:0] mask;
    } regs_t;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irq_stat_regs.sv
module irq_stat_regs
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    set_vec,
    input  logic             rd_stat,
    input  logic             wr_mask,
    input  logic [LANES-1:0] be,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    stat_q,
    output logic [DW-1:0]    mask_q
);
    regs_t r_d, r_q;
    logic [DW-1:0] lane_bits;
    logic [DW-1:0] clr_vec;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_bits[8*i +: 8] = {8{be[i]}};
    end

    always_comb begin
        clr_vec = '0;
        if (rd_stat && be[LOW_LANE])  clr_vec = clr_vec | LOW_GRP;
        if (rd_stat && be[HIGH_LANE]) clr_vec = clr_vec | HIGH_GRP;
        r_d = r_q;
        // set has priority over a clearing read in the same cycle
        r_d.stat = ((r_q.stat & ~clr_vec) | set_vec) & IMPL;
        if (wr_mask)
            r_d.mask = ((r_q.mask & ~lane_bits) | (wdata & lane_bits)) & MASKABLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign stat_q = r_q.stat;
    assign mask_q = r_q.mask;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [LANES-1:0]  acc_be,
    input  logic [DW-1:0]     acc_wdata,
    output logic [DW-1:0]     acc_rdata,
    input  logic              tmr0_evt,
    input  logic              tmr1_evt,
    input  logic              uart_rx_full,
    input  logic              uart_tx_empty,
    input  logic              uart_line_st,
    input  logic              uart_modem_st,
    input  logic              ext_evt,
    input  logic              wake_evt,
    input  logic              per0_req,
    input  logic              per1_req,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] STAT_OFF = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] MASK_OFF = ADDR_W'(4);

    logic [NSRC-1:0] src_lvl, src_rise;
    logic [DW-1:0]   set_vec, stat_q, mask_q;
    logic            rd_stat, wr_mask, uart_any;
    logic            irq_d, irq_q;

    assign uart_any = uart_rx_full | uart_tx_empty | uart_line_st | uart_modem_st;
    assign src_lvl  = {per1_req, per0_req, wake_evt, ext_evt, uart_any, tmr1_evt, tmr0_evt};

    irq_edge_det #(.N(NSRC)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (src_lvl),
        .rise (src_rise)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[B_TM0]  = src_rise[0];
        set_vec[B_TM1]  = src_rise[1];
        set_vec[B_UART] = src_rise[2];
        set_vec[B_EXT]  = src_rise[3];
        set_vec[B_WAKE] = src_rise[4];
        set_vec[B_PER0] = src_rise[5];
        set_vec[B_PER1] = src_rise[6];
    end

    assign rd_stat = acc_en && !acc_wr && (acc_addr == STAT_OFF);
    assign wr_mask = acc_en &&  acc_wr && (acc_addr == MASK_OFF);

    irq_stat_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .rd_stat(rd_stat),
        .wr_mask(wr_mask),
        .be     (acc_be),
        .wdata  (acc_wdata),
        .stat_q (stat_q),
        .mask_q (mask_q)
    );

    always_comb begin
        irq_d = (|(stat_q & mask_q & MASKABLE)) | stat_q[B_PER0] | stat_q[B_PER1]
              | per0_req | per1_req;
        acc_rdata = '0;
        if (acc_addr == STAT_OFF)      acc_rdata = stat_q;
        else if (acc_addr == MASK_OFF) acc_rdata = mask_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
    import irq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic              acc_wr,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [LANES-1:0]  acc_be,
    input logic [DW-1:0]     acc_rdata,
    input logic [DW-1:0]     stat_q,
    input logic [DW-1:0]     mask_q,
    input logic [DW-1:0]     set_vec,
    input logic              per0_req,
    input logic              irq_o
);
    logic rd_s;
    assign rd_s = acc_en && !acc_wr && (acc_addr == '0);

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_s |-> ((acc_rdata & ~IMPL) == '0)); // R2
    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[B_TM0] && !(rd_s && acc_be[LOW_LANE])) |=> stat_q[B_TM0]); // R3
    AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_s && acc_be[LOW_LANE] && (set_vec[4:0] == '0)) |=> (stat_q[4:0] == '0)); // R4
    AST_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_s && acc_be[HIGH_LANE] && (set_vec[17:16] == '0)) |=> (stat_q[17:16] == '0)); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[B_TM1] |=> stat_q[B_TM1]); // R6
    AST_MASK_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q & ~MASKABLE) == '0); // R7
    AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_q[4:0] & mask_q[4:0])) |=> irq_o); // R8
    AST_UNMASKABLE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[B_PER0] |=> irq_o); // R9
    AST_PERIPH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        per0_req |=> irq_o); // R10
endmodule

bind irq_status_ctrl irq_status_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (acc_en),
    .acc_wr   (acc_wr),
    .acc_addr (acc_addr),
    .acc_be   (acc_be),
    .acc_rdata(acc_rdata),
    .stat_q   (stat_q),
    .mask_q   (mask_q),
    .set_vec  (set_vec),
    .per0_req (per0_req),
    .irq_o    (irq_o)
);

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, acc_wr = 1'b0;
    logic [3:0]  acc_addr = '0;
    logic [3:0]  acc_be = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [9:0]  src = '0;
    logic        irq_o;
    int checks = 0, errors = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    irq_status_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_be(acc_be),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .tmr0_evt(src[0]), .tmr1_evt(src[1]),
        .uart_rx_full(src[2]), .uart_tx_empty(src[3]),
        .uart_line_st(src[4]), .uart_modem_st(src[5]),
        .ext_evt(src[6]), .wake_evt(src[7]),
        .per0_req(src[8]), .per1_req(src[9]),
        .irq_o(irq_o)
    );

    // source pattern (bit order as src above) -> expected status
    localparam logic [41:0] VEC [11] = '{
        {10'h001, 32'h0000_0001}, {10'h002, 32'h0000_0002},
        {10'h004, 32'h0000_0004}, {10'h008, 32'h0000_0004},
        {10'h010, 32'h0000_0004}, {10'h020, 32'h0000_0004},
        {10'h040, 32'h0000_0008}, {10'h080, 32'h0000_0010},
        {10'h100, 32'h0001_0000}, {10'h200, 32'h0002_0000},
        {10'h3FF, 32'h0003_001F}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic [3:0] a, logic [3:0] be, output logic [31:0] d);
        acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a; acc_be = be;
        #1 d = acc_rdata;
        @(posedge clk); @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic wr(logic [3:0] a, logic [3:0] be, logic [31:0] d);
        acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_be = be; acc_wdata = d;
        @(posedge clk); @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic ev(logic [9:0] p);
        src = p;
        @(negedge clk);
        src = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(4'h0, 4'hF, rv); check("R1 status reset", rv, 32'h0);
        rd(4'h4, 4'hF, rv); check("R1 mask reset", rv, 32'h0);
        check("R1 irq reset", {31'h0, irq_o}, 32'h0);

        // table walk: R2 positions, R11 UART OR, R4/R5 full clear
        for (int i = 0; i < 11; i++) begin
            ev(VEC[i][41:32]);
            rd(4'h0, 4'hF, rv); check("R2 R11 status bits", rv, VEC[i][31:0]);
            rd(4'h0, 4'hF, rv); check("R4 R5 cleared by read", rv, 32'h0);
        end

        // R7 mask register
        wr(4'h4, 4'hF, 32'hFFFF_FFFF);
        rd(4'h4, 4'hF, rv); check("R7 mask implemented bits", rv, 32'h1F);
        wr(4'h4, 4'hE, 32'h0);
        rd(4'h4, 4'hF, rv); check("R7 lane not enabled kept", rv, 32'h1F);
        wr(4'h4, 4'h1, 32'h0000_0001);
        rd(4'h4, 4'hF, rv); check("R7 lane write", rv, 32'h1);

        // R8 masked source leaves irq low; enabled one raises it one clock later
        ev(10'h002);
        @(negedge clk);
        check("R8 masked no irq", {31'h0, irq_o}, 32'h0);
        src = 10'h001;
        @(negedge clk);
        check("R8 irq not yet", {31'h0, irq_o}, 32'h0);
        src = 10'h000;
        @(negedge clk);
        check("R8 irq one clock after status", {31'h0, irq_o}, 32'h1);

        // R12 status write ignored
        wr(4'h0, 4'hF, 32'h0);
        rd(4'h0, 4'hE, rv); check("R12 write ignored", rv, 32'h3);
        // R4 no lane 0 -> bits kept
        rd(4'h0, 4'h0, rv); check("R4 no lane0 keeps", rv, 32'h3);
        rd(4'h0, 4'h1, rv); check("R4 lane0 read value", rv, 32'h3);
        rd(4'h0, 4'hF, rv); check("R4 lane0 cleared", rv, 32'h0);
        @(negedge clk);
        check("R8 irq drops", {31'h0, irq_o}, 32'h0);

        // R3 held input sets once
        src = 10'h001;
        @(negedge clk);
        rd(4'h0, 4'h1, rv); check("R3 set by edge", rv, 32'h1);
        rd(4'h0, 4'h1, rv); check("R3 held level no reset", rv, 32'h0);
        src = 10'h000;
        @(negedge clk);

        // R6 set and clearing read in same cycle
        src = 10'h002;
        rd(4'h0, 4'h1, rv); check("R6 old value in read", rv, 32'h0);
        src = 10'h000;
        rd(4'h0, 4'h1, rv); check("R6 set wins", rv, 32'h2);

        // R9/R10/R5 peripheral requests, mask all off
        wr(4'h4, 4'hF, 32'h0);
        src = 10'h100;
        @(negedge clk);
        check("R9 unmaskable irq", {31'h0, irq_o}, 32'h1);
        rd(4'h0, 4'h1, rv); check("R5 lane0 read keeps bit16", rv, 32'h1_0000);
        rd(4'h0, 4'h4, rv); check("R5 lane2 read value", rv, 32'h1_0000);
        rd(4'h0, 4'hF, rv); check("R5 bit16 cleared", rv, 32'h0);
        @(negedge clk);
        check("R10 irq held by request", {31'h0, irq_o}, 32'h1);
        src = 10'h000;
        @(negedge clk);
        check("R10 irq drops after request", {31'h0, irq_o}, 32'h0);

        // R9 pending bit alone keeps irq
        ev(10'h200);
        @(negedge clk);
        check("R9 pending bit17 irq", {31'h0, irq_o}, 32'h1);
        rd(4'h0, 4'h4, rv);
        @(negedge clk);
        check("R9 irq low after clear", {31'h0, irq_o}, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule